// File: doc/BRIEF.md
# SRAM Retention Entry Sequencer

This block watches the access path of a group of SRAM banks. When no access has been requested for a programmable number of slow-oscillator ticks, it puts the banks into a low-leakage retention state. Banks go in one at a time, with a programmable gap in functional clocks between them. A new access request brings the banks back out in the same order and with the same gap. Access is then held off for a programmable wake latency before the path reports ready again.

Each bank has two retention controls: a sleep control and a bit-line-float control. Two disable inputs can hold either kind of control low. The disable inputs do not change the state sequence or its timing. Both time bases share one clock domain. The slow oscillator appears as a single-cycle enable, `osc_tick`.

Top module: `sram_ret_seq`

## Requirements
- R1: While reset is asserted and right after it, `acc_ready` is 1, `ret_flag` is 0, and every bit of `bank_sleep` and `bank_blf` is 0.
- R2: The 3-bit `idle_code` c selects an idle wait of 4·2^c `osc_tick` pulses (codes 0 to 7 give 4 to 512). The wait is counted while `acc_req` is low, and retention entry starts once the wait is complete.
- R3: If `acc_req` goes high at any point during the idle wait, the wait is cancelled. The full wait is counted again after `acc_req` next goes low.
- R4: The 2-bit `stag_code` s sets the stagger. With s = 0, all banks enter together. With s = 1, 2 or 3, bank k+1 enters s clock cycles after bank k. Bank 0 always enters first, and the banks enter in ascending index order.
- R5: On exit, the banks leave retention in ascending index order, starting with bank 0, using the same spacing of s cycles. With s = 0 they all leave together.
- R6: After the last bank has left retention, `acc_ready` stays low for 2^w cycles, where w is the 3-bit `wake_code` (1 to 128 cycles). It then rises.
- R7: `acc_ready` is high only in the active and idle-counting states. `ret_flag` is high only while every bank is held in retention and no transition is in progress. The two flags are never high at the same time.
- R8: While `sleep_dis` is 1, `bank_sleep` stays all zero. The sequence and its timing are unchanged, and this can be seen on `bank_blf` and `ret_flag`.
- R9: While `blf_dis` is 1, `bank_blf` stays all zero. The sequence and its timing are unchanged, and this can be seen on `bank_sleep` and `ret_flag`.
- R10: If `acc_req` rises during staggered entry, the entry is abandoned. `ret_flag` never rises, and the banks that have already entered are released in exit order. After the wake latency, `acc_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Single-cycle enable marking one slow-oscillator tick |
| acc_req | input | 1 | Access request from the SRAM path |
| idle_code | input | 3 | Idle wait selector, 4·2^code ticks |
| stag_code | input | 2 | Bank stagger, 0 = simultaneous, else cycles between banks |
| wake_code | input | 3 | Wake latency selector, 2^code cycles |
| sleep_dis | input | 1 | Keeps all sleep controls low |
| blf_dis | input | 1 | Keeps all bit-line-float controls low |
| bank_sleep | output | NUM_BANKS | Per-bank sleep control |
| bank_blf | output | NUM_BANKS | Per-bank bit-line-float control |
| acc_ready | output | 1 | Access may proceed |
| ret_flag | output | 1 | All banks are settled in retention |

## Verification
A wrong bank pointer or gap counter appears on the bank outputs within one cycle of the bad step. The outputs lose their contiguous shape, or a bank switches on the wrong cycle. A timer that is off by one moves the rise of `ret_flag` or `acc_ready` by exactly one cycle, and the sweeps compare these edges against closed-form cycle counts. A wrong state transition shows up within a cycle or two as `acc_ready` being high while banks are retained, or as `ret_flag` rising after an aborted entry.

// File: rtl/sret_pkg.sv
package sret_pkg;
   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_IDLE   = 3'd1,
      ST_ENTER  = 3'd2,
      ST_RET    = 3'd3,
      ST_EXIT   = 3'd4,
      ST_WAKE   = 3'd5
   } sret_state_e;
endpackage

// File: rtl/sret_log_timer.sv
// Counts up to a power-of-two limit, 2^(BASE_LOG+code), and reports the final count.
// When USE_TICK is set, it advances only on the enable pulse. Otherwise it advances every cycle.
module sret_log_timer #(
   parameter int CODE_W   = 3,
   parameter int BASE_LOG = 2,
   parameter bit USE_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              done
);
   localparam int MAX_LOG = BASE_LOG + (1 << CODE_W) - 1;
   localparam int CNT_W   = MAX_LOG + 1;

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code_w
      $error("sret_log_timer: CODE_W must be 1..4");
   end
   if (BASE_LOG < 0) begin : g_bad_base
      $error("sret_log_timer: BASE_LOG must be non-negative");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_m1;
   logic             adv;

   assign lim_m1 = (CNT_W'(1) << (BASE_LOG + int'(code))) - CNT_W'(1);

   if (USE_TICK) begin : g_ticked
      assign adv = tick;
   end else begin : g_every
      assign adv = 1'b1;
   end

   assign done = run && adv && (cnt == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || done)   cnt <= '0;
      else if (adv)            cnt <= cnt + CNT_W'(1);
   end

   assert_timer_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run && $stable(code) |-> cnt <= lim_m1);
endmodule

// File: rtl/sret_bank_stagger.sv
// Steps a bank pointer through the banks, setting or clearing one retention mask bit at each step.
module sret_bank_stagger #(
   parameter int NUM_BANKS = 4,
   parameter int STAG_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic                 enter_run,
   input  logic                 exit_run,
   input  logic [STAG_W-1:0]    stag_code,
   output logic [NUM_BANKS-1:0] mask,
   output logic                 enter_done,
   output logic                 exit_done
);
   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BANKS - 1);

   if (NUM_BANKS < 1 || NUM_BANKS > 64) begin : g_bad_nb
      $error("sret_bank_stagger: NUM_BANKS must be 1..64");
   end

   logic [IDX_W-1:0]     idx;
   logic [STAG_W-1:0]    gap;
   logic [NUM_BANKS-1:0] sel;
   logic                 bulk;
   logic                 step;

   assign sel  = NUM_BANKS'(1) << idx;
   assign bulk = (stag_code == '0);
   assign step = (gap == '0);

   assign enter_done = enter_run && (bulk || (step && idx == LAST));
   assign exit_done  = exit_run  && (bulk || (step && ((mask & ~sel) == '0)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
         gap <= '0;
      end else if (restart) begin
         idx <= '0;
         gap <= '0;
      end else if ((enter_run || exit_run) && !bulk) begin
         if (step) begin
            idx <= idx + IDX_W'(1);
            gap <= stag_code - STAG_W'(1);
         end else begin
            gap <= gap - STAG_W'(1);
         end
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask[b] <= 1'b0;
         end else if (!restart && enter_run && (bulk || (step && idx == IDX_W'(b)))) begin
            mask[b] <= 1'b1;
         end else if (!restart && exit_run && (bulk || (step && idx == IDX_W'(b)))) begin
            mask[b] <= 1'b0;
         end
      end
   end

   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stag_code) != '0 && $stable(stag_code) |-> $countones(mask ^ $past(mask)) <= 1);
   assert_no_mixed_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(enter_run && exit_run));
endmodule

// File: rtl/sram_ret_seq.sv
module sram_ret_seq #(
   parameter int NUM_BANKS = 4,
   parameter int IDLE_W    = 3,
   parameter int STAG_W    = 2,
   parameter int WAKE_W    = 3,
   parameter int IDLE_BASE = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 osc_tick,
   input  logic                 acc_req,
   input  logic [IDLE_W-1:0]    idle_code,
   input  logic [STAG_W-1:0]    stag_code,
   input  logic [WAKE_W-1:0]    wake_code,
   input  logic                 sleep_dis,
   input  logic                 blf_dis,
   output logic [NUM_BANKS-1:0] bank_sleep,
   output logic [NUM_BANKS-1:0] bank_blf,
   output logic                 acc_ready,
   output logic                 ret_flag
);
   import sret_pkg::*;

   if (STAG_W < 1 || STAG_W > 4) begin : g_bad_stag
      $error("sram_ret_seq: STAG_W must be 1..4");
   end

   sret_state_e          state, nxt;
   logic                 idle_done, wake_done;
   logic                 enter_done, exit_done;
   logic                 restart;
   logic [NUM_BANKS-1:0] mask;

   sret_log_timer #(.CODE_W(IDLE_W), .BASE_LOG(IDLE_BASE), .USE_TICK(1'b1)) u_idle (
      .clk(clk), .rst_n(rst_n), .run(state == ST_IDLE && !acc_req),
      .tick(osc_tick), .code(idle_code), .done(idle_done));

   sret_log_timer #(.CODE_W(WAKE_W), .BASE_LOG(0), .USE_TICK(1'b0)) u_wake (
      .clk(clk), .rst_n(rst_n), .run(state == ST_WAKE),
      .tick(1'b0), .code(wake_code), .done(wake_done));

   sret_bank_stagger #(.NUM_BANKS(NUM_BANKS), .STAG_W(STAG_W)) u_stag (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .enter_run(state == ST_ENTER && !acc_req),
      .exit_run(state == ST_EXIT), .stag_code(stag_code),
      .mask(mask), .enter_done(enter_done), .exit_done(exit_done));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_ACTIVE: if (!acc_req) nxt = ST_IDLE;
         ST_IDLE:   if (acc_req) nxt = ST_ACTIVE;
                    else if (idle_done) nxt = ST_ENTER;
         ST_ENTER:  if (acc_req) nxt = ST_EXIT;
                    else if (enter_done) nxt = ST_RET;
         ST_RET:    if (acc_req) nxt = ST_EXIT;
         ST_EXIT:   if (exit_done) nxt = ST_WAKE;
         ST_WAKE:   if (wake_done) nxt = ST_ACTIVE;
         default:   nxt = ST_ACTIVE;
      endcase
   end

   assign restart = (nxt == ST_ENTER && state != ST_ENTER) ||
                    (nxt == ST_EXIT && state != ST_EXIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_ACTIVE;
      else        state <= nxt;
   end

   assign acc_ready = (state == ST_ACTIVE) || (state == ST_IDLE);
   assign ret_flag  = (state == ST_RET);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_out
      assign bank_sleep[b] = mask[b] & ~sleep_dis;
      assign bank_blf[b]   = mask[b] & ~blf_dis;
   end

   assert_ready_banks_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ready |-> mask == '0);
   assert_retained_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_flag |-> &mask);
   assert_wake_before_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_ready) |-> $past(state) == ST_WAKE);
   assert_idle_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE && acc_req |=> state == ST_ACTIVE);
   assert_abort_exits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ENTER && acc_req |=> state == ST_EXIT);
endmodule

// File: tb/tb_sram_ret_seq.sv
module tb_sram_ret_seq;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          osc_tick = 1'b1;
   logic          acc_req = 1'b1;
   logic [2:0]    idle_code = 3'd0;
   logic [1:0]    stag_code = 2'd1;
   logic [2:0]    wake_code = 3'd1;
   logic          sleep_dis = 1'b0;
   logic          blf_dis = 1'b0;
   logic [NB-1:0] bank_sleep, bank_blf;
   logic          acc_ready, ret_flag;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   sram_ret_seq #(.NUM_BANKS(NB)) dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .acc_req(acc_req),
      .idle_code(idle_code), .stag_code(stag_code), .wake_code(wake_code),
      .sleep_dis(sleep_dis), .blf_dis(blf_dis), .bank_sleep(bank_sleep),
      .bank_blf(bank_blf), .acc_ready(acc_ready), .ret_flag(ret_flag));

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Releases the request and follows the entry sequence until ret_flag rises.
   task automatic run_entry(input int s, input int lim_idle, input bit sdis, input bit bdis);
      int n = 0;
      int first[NB];
      int shape_bad = 0;
      int sleep_bad = 0;
      int blf_bad = 0;
      logic [NB-1:0] obs;
      for (int k = 0; k < NB; k++) first[k] = -1;
      sleep_dis = sdis;
      blf_dis = bdis;
      acc_req = 1'b0;
      while (!ret_flag && n < 3000) begin
         cyc();
         n++;
         obs = sdis ? bank_blf : bank_sleep;
         if (obs != NB'((1 << $countones(obs)) - 1)) shape_bad++;
         if (sdis && bank_sleep != '0) sleep_bad++;
         if (bdis && bank_blf != '0) blf_bad++;
         if (!ret_flag && acc_ready == 1'b0 && n <= lim_idle) shape_bad++;
         for (int k = 0; k < NB; k++) if (obs[k] && first[k] < 0) first[k] = n;
      end
      chk(n == 2 + lim_idle + (NB - 1) * s, "R2 entry cycles", n, 2 + lim_idle + (NB - 1) * s);
      chk(shape_bad == 0, "R4 ascending entry order", shape_bad, 0);
      for (int k = 0; k < NB; k++)
         chk(first[k] == 2 + lim_idle + k * s, "R4 bank entry cycle", first[k], 2 + lim_idle + k * s);
      chk(acc_ready == 1'b0, "R7 ready low when retained", int'(acc_ready), 0);
      if (sdis) chk(sleep_bad == 0, "R8 sleep held low", sleep_bad, 0);
      if (bdis) chk(blf_bad == 0, "R9 blf held low", blf_bad, 0);
   endtask

   // Raises the request and follows the exit sequence until acc_ready rises.
   task automatic run_exit(input int s, input int lim_wake, input bit sdis);
      int n = 0;
      int gone[NB];
      int shape_bad = 0;
      int ret_bad = 0;
      logic [NB-1:0] obs;
      logic [NB-1:0] full;
      full = '1;
      for (int k = 0; k < NB; k++) gone[k] = -1;
      acc_req = 1'b1;
      while (!acc_ready && n < 3000) begin
         cyc();
         n++;
         obs = sdis ? bank_blf : bank_sleep;
         if (obs != (full & ~NB'((1 << (NB - $countones(obs))) - 1))) shape_bad++;
         if (ret_flag) ret_bad++;
         for (int k = 0; k < NB; k++) if (!obs[k] && gone[k] < 0) gone[k] = n;
      end
      chk(n == 2 + (NB - 1) * s + lim_wake, "R6 exit to ready cycles", n, 2 + (NB - 1) * s + lim_wake);
      chk(shape_bad == 0, "R5 ascending exit order", shape_bad, 0);
      chk(ret_bad == 0, "R7 ret_flag low during exit", ret_bad, 0);
      for (int k = 0; k < NB; k++)
         chk(gone[k] == 2 + k * s, "R5 bank exit cycle", gone[k], 2 + k * s);
      sleep_dis = 1'b0;
      blf_dis = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int n;
      int bad;
      repeat (3) cyc();
      chk(acc_ready == 1'b1, "R1 ready in reset", int'(acc_ready), 1);
      chk(ret_flag == 1'b0, "R1 ret_flag in reset", int'(ret_flag), 0);
      chk(bank_sleep == '0 && bank_blf == '0, "R1 banks in reset", int'(bank_sleep | bank_blf), 0);
      rst_n = 1'b1;
      repeat (2) cyc();
      chk(acc_ready == 1'b1 && bank_sleep == '0, "R1 after reset", int'(acc_ready), 1);

      // Idle wait sweep over all codes, stagger 1, wake 2.
      for (int c = 0; c < 8; c++) begin
         idle_code = 3'(c);
         stag_code = 2'd1;
         wake_code = 3'd1;
         run_entry(1, 4 << c, 1'b0, 1'b0);
         run_exit(1, 2, 1'b0);
      end

      // Stagger and wake cross sweep, shortest idle wait.
      idle_code = 3'd0;
      for (int s = 0; s < 4; s++) begin
         for (int w = 0; w < 8; w++) begin
            stag_code = 2'(s);
            wake_code = 3'(w);
            run_entry(s, 4, 1'b0, 1'b0);
            run_exit(s, 1 << w, 1'b0);
         end
      end

      // R3: a pulse of acc_req in the middle of the idle wait restarts it.
      idle_code = 3'd2;
      stag_code = 2'd1;
      wake_code = 3'd1;
      acc_req = 1'b0;
      bad = 0;
      for (int i = 0; i < 12; i++) begin
         cyc();
         if (ret_flag || bank_sleep != '0) bad++;
      end
      acc_req = 1'b1;
      cyc();
      chk(acc_ready == 1'b1 && bank_sleep == '0, "R3 still active after pulse", bad, 0);
      run_entry(1, 16, 1'b0, 1'b0);
      run_exit(1, 2, 1'b0);

      // R8 and R9: the disable bits mask outputs without moving the timing.
      idle_code = 3'd0;
      stag_code = 2'd2;
      run_entry(2, 4, 1'b1, 1'b0);
      chk(bank_blf == '1, "R8 blf still set with sleep disabled", int'(bank_blf), (1 << NB) - 1);
      run_exit(2, 2, 1'b1);
      run_entry(2, 4, 1'b0, 1'b1);
      chk(bank_sleep == '1, "R9 sleep still set with blf disabled", int'(bank_sleep), (1 << NB) - 1);
      run_exit(2, 2, 1'b0);

      // R10: a request after the first bank has entered aborts the entry.
      stag_code = 2'd3;
      wake_code = 3'd1;
      acc_req = 1'b0;
      n = 0;
      while (bank_sleep == '0 && n < 100) begin
         cyc();
         n++;
      end
      chk(bank_sleep == 4'b0001, "R10 first bank entered", int'(bank_sleep), 1);
      acc_req = 1'b1;
      n = 0;
      bad = 0;
      while (!acc_ready && n < 100) begin
         cyc();
         n++;
         if (ret_flag) bad++;
      end
      chk(bad == 0, "R10 ret_flag never rises", bad, 0);
      chk(n == 4, "R10 abort to ready cycles", n, 4);
      chk(bank_sleep == '0 && bank_blf == '0, "R10 banks released", int'(bank_sleep), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule